// File: doc/BRIEF.md
# Retry-Aging Priority Field Generator

This block forms the contention priority that travels with a head-of-line cell into the routing fabric. The field has three parts. A connection priority is captured from the routing table lookup when a new cell reaches the head of the line. A retry age counter starts at its weakest value and steps one level stronger each time the cell fails to get through. A rotating tie-break counter, seeded with the port's own input address, steps once per cell time so that inputs with equal connection priority and equal age take turns winning.

A smaller field value means a stronger priority, so both counters count down. The retry age counter saturates at zero and stays there until the next head-of-line cell arrives. All state advances only on a cell-time strobe. The routing table lookup and the priority comparison are outside the block.

Top module: `prio_field_gen`

## Requirements
- R1: While reset is asserted and after it is released, the tie-break counter equals `portAddr`, the retry age is all ones and the captured connection priority is all ones, until the first cell-time strobe.
- R2: On every cycle with `cellTick` high, the tie-break counter decreases by one, wrapping from zero to its all-ones value (255 at the default width of 8 bits).
- R3: On a cycle with `cellTick` low, the whole output field keeps its value, whatever `newHol`, `txFail` and `connPrio` are doing. These events have no later effect either.
- R4: On a cycle with `cellTick` and `txFail` high and `newHol` low, a nonzero retry age decreases by one.
- R5: A retry age of zero stays at zero on further failures until a new head-of-line cell arrives.
- R6: On a cycle with `cellTick` and `newHol` high, the retry age reloads to all ones, even if `txFail` is high in the same cycle.
- R7: On a cycle with `cellTick` and `newHol` high, `connPrio` is captured into the field. At every other time the captured value holds.
- R8: `prioField` is the concatenation {connection priority, retry age, tie-break counter}, with the connection priority in the most significant bits (widths 4, 4 and 8 by default, 16 bits in total).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cellTick | input | 1 | One-cycle strobe marking a cell time |
| newHol | input | 1 | A new cell has become head of line (qualified by cellTick) |
| txFail | input | 1 | The head-of-line cell failed to route this cell time (qualified by cellTick) |
| connPrio | input | C_W (4) | Connection priority from the routing table |
| portAddr | input | S_W (8) | This port's input address, used as the reset seed |
| prioField | output | C_W+R_W+S_W (16) | Priority field, where a lower value means stronger |

## Verification
The bench first runs bare cell ticks with no events. This separates a correct tie-break decrement and wrap-around from an off-by-one or a missing wrap. It then runs a long run of consecutive failures that passes through zero. This shows whether the age counter decrements on failures, and whether it saturates or instead wraps or stops early. Cycles that carry events without a cell tick show whether the strobe gate is honoured. A new cell that arrives together with a failure shows which of the two wins.

// File: rtl/prio_field_pkg.sv
package prio_field_pkg;
  // strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic sStep;   // advance the tie-break counter
    logic rLoad;   // restart retry age at all ones
    logic rStep;   // age the cell by one level
    logic cLoad;   // capture connection priority
  } prio_strobe_t;
endpackage

// File: rtl/prio_field_ctrl.sv
module prio_field_ctrl
  import prio_field_pkg::*;
(
  input  logic         cellTick,
  input  logic         newHol,
  input  logic         txFail,
  input  logic         rZero,
  output prio_strobe_t strb
);
  always_comb begin
    strb.sStep = cellTick;
    strb.rLoad = cellTick & newHol;
    // a new cell outranks a failure report in the same cell time
    strb.rStep = cellTick & ~newHol & txFail & ~rZero;
    strb.cLoad = cellTick & newHol;
  end
endmodule

// File: rtl/prio_field_dp.sv
module prio_field_dp
  import prio_field_pkg::*;
#(
  parameter int C_W = 4,
  parameter int R_W = 4,
  parameter int S_W = 8,
  localparam int F_W = C_W + R_W + S_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  prio_strobe_t   strb,
  input  logic [C_W-1:0] connPrio,
  input  logic [S_W-1:0] portAddr,
  output logic           rZero,
  output logic [F_W-1:0] prioField
);
  logic [S_W-1:0] sCnt;
  logic [R_W-1:0] rCnt;
  logic [C_W-1:0] cReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sCnt <= portAddr;
    end else if (strb.sStep) begin
      sCnt <= sCnt - S_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rCnt <= '1;
    end else if (strb.rLoad) begin
      rCnt <= '1;
    end else if (strb.rStep) begin
      rCnt <= rCnt - R_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cReg <= '1;
    end else if (strb.cLoad) begin
      cReg <= connPrio;
    end
  end

  assign rZero     = (rCnt == '0);
  assign prioField = {cReg, rCnt, sCnt};
endmodule

// File: rtl/prio_field_gen.sv
module prio_field_gen
  import prio_field_pkg::*;
#(
  parameter int C_W = 4,
  parameter int R_W = 4,
  parameter int S_W = 8,
  localparam int F_W = C_W + R_W + S_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cellTick,
  input  logic           newHol,
  input  logic           txFail,
  input  logic [C_W-1:0] connPrio,
  input  logic [S_W-1:0] portAddr,
  output logic [F_W-1:0] prioField
);
  prio_strobe_t strb;
  logic         rZero;

  prio_field_ctrl u_ctrl (
    .cellTick (cellTick),
    .newHol   (newHol),
    .txFail   (txFail),
    .rZero    (rZero),
    .strb     (strb)
  );

  prio_field_dp #(.C_W(C_W), .R_W(R_W), .S_W(S_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .connPrio  (connPrio),
    .portAddr  (portAddr),
    .rZero     (rZero),
    .prioField (prioField)
  );
endmodule

// File: rtl/prio_field_gen_chk.sv
module prio_field_gen_chk #(
  parameter int C_W = 4,
  parameter int R_W = 4,
  parameter int S_W = 8,
  localparam int F_W = C_W + R_W + S_W
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cellTick,
  input logic           newHol,
  input logic           txFail,
  input logic [C_W-1:0] connPrio,
  input logic [F_W-1:0] prioField
);
  logic [S_W-1:0] sF;
  logic [R_W-1:0] rF;
  logic [C_W-1:0] cF;
  assign sF = prioField[S_W-1:0];
  assign rF = prioField[S_W +: R_W];
  assign cF = prioField[F_W-1 -: C_W];

  p_s_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cellTick |=> sF == $past(sF) - S_W'(1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cellTick |=> $stable(prioField));

  p_r_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cellTick && txFail && !newHol && rF != '0) |=> rF == $past(rF) - R_W'(1));

  p_r_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cellTick && !newHol && rF == '0) |=> rF == '0);

  p_r_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cellTick && newHol) |=> rF == '1);

  p_c_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cellTick && newHol) |=> cF == $past(connPrio));

  p_c_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cellTick && newHol) |=> $stable(cF));
endmodule

bind prio_field_gen prio_field_gen_chk #(.C_W(C_W), .R_W(R_W), .S_W(S_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cellTick  (cellTick),
  .newHol    (newHol),
  .txFail    (txFail),
  .connPrio  (connPrio),
  .prioField (prioField)
);

// File: tb/prio_field_gen_bench.sv
`timescale 1ns/1ps
module prio_field_gen_bench;
  localparam int C_W = 4;
  localparam int R_W = 4;
  localparam int S_W = 8;
  localparam int F_W = C_W + R_W + S_W;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cellTick = 1'b0;
  logic           newHol = 1'b0;
  logic           txFail = 1'b0;
  logic [C_W-1:0] connPrio = '0;
  logic [S_W-1:0] portAddr = 8'd5;
  logic [F_W-1:0] prioField;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // behavioural reference state
  int mS, mR, mC;

  always #2 clk = ~clk;

  prio_field_gen #(.C_W(C_W), .R_W(R_W), .S_W(S_W)) u_prio_field_gen (
    .clk(clk), .rst_n(rst_n), .cellTick(cellTick), .newHol(newHol),
    .txFail(txFail), .connPrio(connPrio), .portAddr(portAddr),
    .prioField(prioField)
  );

  function automatic int expField();
    return (mC << (R_W + S_W)) | (mR << S_W) | mS;
  endfunction

  task automatic check(input string tag);
    nChecks++;
    if (prioField !== F_W'(expField())) begin
      nFails++;
      $display("FAIL %s: prioField actual 0x%0h expected 0x%0h", tag, prioField, expField());
    end
  endtask

  task automatic doReset(input logic [S_W-1:0] addr);
    @(negedge clk);
    portAddr = addr;
    rst_n = 1'b0;
    cellTick = 1'b0; newHol = 1'b0; txFail = 1'b0;
    mS = addr; mR = (1 << R_W) - 1; mC = (1 << C_W) - 1;
    @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
  endtask

  task automatic step(input logic t, input logic nh, input logic f,
                      input int cp, input string tag);
    cellTick = t; newHol = nh; txFail = f; connPrio = C_W'(cp);
    @(posedge clk);
    if (t) begin
      mS = (mS - 1) & ((1 << S_W) - 1);
      if (nh) begin
        mR = (1 << R_W) - 1;
        mC = cp;
      end else if (f && mR > 0) begin
        mR = mR - 1;
      end
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    doReset(8'd5);
    // R3: events without a cell tick are ignored
    step(0, 0, 0, 0, "R3");
    step(0, 1, 1, 2, "R3");
    step(0, 0, 1, 7, "R3");
    // R7: new cell captures connection priority
    step(1, 1, 0, 3, "R7");
    // R2: bare ticks pass through zero and wrap
    for (int i = 0; i < 8; i++) step(1, 0, 0, 0, "R2");
    // R4 then R5: long run of failures
    for (int i = 0; i < 15; i++) step(1, 0, 1, 0, "R4");
    for (int i = 0; i < 3; i++)  step(1, 0, 1, 0, "R5");
    step(0, 0, 1, 0, "R3");
    step(1, 0, 0, 0, "R5");
    // R6: new cell together with a failure
    step(1, 1, 1, 9, "R6");
    step(1, 0, 1, 9, "R4");
    step(1, 0, 1, 4, "R7");
    step(1, 1, 0, 0, "R7");
    // R8: explicit slice positions
    nChecks++;
    if (prioField[F_W-1 -: C_W] !== 4'd0 || prioField[S_W +: R_W] !== 4'hF ||
        prioField[S_W-1:0] !== S_W'(mS)) begin
      nFails++;
      $display("FAIL R8: prioField actual 0x%0h expected 0x%0h", prioField, expField());
    end
    // R1 and R2: reseed at address zero, one tick wraps to 255
    doReset(8'd0);
    step(1, 0, 0, 0, "R2");
    nChecks++;
    if (prioField[S_W-1:0] !== 8'd255) begin
      nFails++;
      $display("FAIL R2: tie-break actual %0d expected 255", prioField[S_W-1:0]);
    end
    step(1, 0, 1, 0, "R4");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule